// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps return addresses for a small pipelined processor core in storage of its own. That storage lies outside both the program and the data address spaces. The instruction control logic asserts a push when a subroutine call executes or when an accepted interrupt forces a branch. The push stores the current program counter. The control logic asserts a pop on any of the three return instructions: plain return, return from interrupt and return with a literal. The entry at the top of the stack drives the program-counter load path with no register in the way. Its value is therefore usable in the same cycle that the pop is requested.

The stack is a ring of `DEPTH` slots (1 to 16, default 8), each `AW` bits wide (up to 16). Software cannot see the pointer. The block raises no overflow or underflow indication, so the pointer simply wraps. A push beyond the depth overwrites the oldest entry. A pop past the bottom lands on whatever slot sits below. A push and a pop in the same cycle is a protocol fault: the push wins and a sticky debug flag records the fault.

Top module: `ret_stack`

## Requirements
- R1: A push writes `push_addr_i` into the slot after the current top. From the following cycle on, `top_o` shows that value.
- R2: A pop with no push moves the pointer back one slot. From the following cycle on, `top_o` shows the entry that was below the old top.
- R3: `top_o` is the slot at the current pointer, taken combinationally. In a cycle with neither push nor pop, `top_o` does not change.
- R4: The slots form a ring: after slot `DEPTH-1` the pointer moves on to slot 0. With the default depth of 8, the ninth consecutive push overwrites the entry written by the first push. The bench uses a depth of 5 to check the wrap where the depth is not a power of two.
- R5: A pop on an empty stack wraps the pointer modulo `DEPTH` and returns the entry it lands on, with no error indication.
- R6: A push and a pop in the same cycle performs only the push. The pop is ignored and `collide_o` goes to 1 on the following cycle.
- R7: Once `collide_o` is 1, it stays 1 until reset, whatever push and pop do.
- R8: Reset (`rst_n` low, synchronous) sets the pointer to slot 0 and clears `collide_o`. It does not clear the stored entries, so after reset one push followed by one pop shows slot 0's earlier content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request from the control logic |
| pop_i | input | 1 | Pop request from the control logic |
| push_addr_i | input | AW | Program-counter value to store on push |
| top_o | output | AW | Entry at the current pointer (combinational) |
| collide_o | output | 1 | Sticky flag: push and pop were requested together |

## Verification
The bench builds one instance with `DEPTH=5` and `AW=12`. That instance reaches the wrap past the last slot on a depth that is not a power of two, the underflow wrap from slot 0, the push/pop collision and the reset of the pointer alone. A second instance with the default parameters (`DEPTH=8`, `AW=16`) shows that the ninth push replaces the first and that the eighth pop then wraps onto the newest entry.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_o,
  output logic          collide_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] slots [DEPTH];
  logic [PW-1:0] ptr, ptr_up, ptr_dn;

  assign ptr_up = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign ptr_dn = (ptr == '0) ? LAST : ptr - 1'b1;
  assign top_o  = slots[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (push_i) ptr <= ptr_up;
    else if (pop_i)  ptr <= ptr_dn;
  end

  always_ff @(posedge clk) begin
    if (rst_n && push_i) slots[ptr_up] <= push_addr_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               collide_o <= 1'b0;
    else if (push_i && pop_i) collide_o <= 1'b1;
  end
endmodule

module ret_stack_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_addr_i,
  input logic [AW-1:0] top_o,
  input logic          collide_o
);
  p_push_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(push_addr_i));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(top_o));

  p_collide_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> collide_o);

  p_collide_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collide_o |=> collide_o);

  p_collide_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!collide_o && !(push_i && pop_i)) |=> !collide_o);
endmodule

bind ret_stack ret_stack_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .push_addr_i(push_addr_i), .top_o(top_o), .collide_o(collide_o)
);

// File: tb/ret_stack_tb.sv
module ret_stack_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [11:0] data = '0;
  logic [11:0] top;
  logic col;
  logic push8 = 1'b0, pop8 = 1'b0;
  logic [15:0] data8 = '0;
  logic [15:0] top8;
  logic col8;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  ret_stack #(.DEPTH(5), .AW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .push_addr_i(data), .top_o(top), .collide_o(col));

  ret_stack u_def (
    .clk(clk), .rst_n(rst_n), .push_i(push8), .pop_i(pop8),
    .push_addr_i(data8), .top_o(top8), .collide_o(col8));

  // {push, pop, data, expected top, expected collide}
  localparam logic [26:0] VEC [16] = '{
    {1'b1, 1'b0, 12'h101, 12'h101, 1'b0},
    {1'b1, 1'b0, 12'h102, 12'h102, 1'b0},
    {1'b0, 1'b1, 12'h000, 12'h101, 1'b0},
    {1'b1, 1'b0, 12'h103, 12'h103, 1'b0},
    {1'b1, 1'b0, 12'h104, 12'h104, 1'b0},
    {1'b1, 1'b0, 12'h105, 12'h105, 1'b0},
    {1'b1, 1'b0, 12'h106, 12'h106, 1'b0},
    {1'b1, 1'b0, 12'h107, 12'h107, 1'b0},
    {1'b0, 1'b1, 12'h000, 12'h106, 1'b0},
    {1'b0, 1'b1, 12'h000, 12'h105, 1'b0},
    {1'b0, 1'b1, 12'h000, 12'h104, 1'b0},
    {1'b0, 1'b1, 12'h000, 12'h103, 1'b0},
    {1'b0, 1'b1, 12'h000, 12'h107, 1'b0},
    {1'b0, 1'b0, 12'h000, 12'h107, 1'b0},
    {1'b1, 1'b1, 12'h1FF, 12'h1FF, 1'b1},
    {1'b0, 1'b1, 12'h000, 12'h107, 1'b1}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 1, 3, 4, 5: return "R1";
      2, 8, 9, 10, 11: return "R2";
      6, 7: return "R4";
      12: return "R5";
      13: return "R3";
      14: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [11:0] d);
    @(negedge clk);
    push = pu; pop = po; data = d;
    @(posedge clk);
    #2;
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic step8(input logic pu, input logic po, input logic [15:0] d);
    @(negedge clk);
    push8 = pu; pop8 = po; data8 = d;
    @(posedge clk);
    #2;
    push8 = 1'b0; pop8 = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R8 reset collide", {15'd0, col}, 16'd0);
    chk("R8 reset collide default", {15'd0, col8}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      step(VEC[i][26], VEC[i][25], VEC[i][24:13]);
      chk(row_tag(i), {4'd0, top}, {4'd0, VEC[i][12:1]});
      chk({row_tag(i), " collide"}, {15'd0, col}, {15'd0, VEC[i][0]});
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    chk("R8 collide cleared", {15'd0, col}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 12'h201);
    chk("R8 push after reset", {4'd0, top}, 16'h0201);
    step(1'b0, 1'b1, 12'h000);
    chk("R8 pointer at slot 0, contents kept", {4'd0, top}, 16'h0106);

    for (int k = 1; k <= 9; k++) step8(1'b1, 1'b0, 16'hA000 + 16'(k));
    chk("R4 ninth push on top", top8, 16'hA009);
    for (int k = 0; k < 7; k++) step8(1'b0, 1'b1, 16'h0000);
    chk("R4 seventh pop", top8, 16'hA002);
    step8(1'b0, 1'b1, 16'h0000);
    chk("R4 first entry overwritten", top8, 16'hA009);
    chk("R5 no flag on underflow", {15'd0, col8}, 16'd0);

    finish_run();
  end
endmodule